// File: doc/BRIEF.md
# SQE Heartbeat Error Counter

This block supervises the signal-quality heartbeat that a half-duplex Ethernet transceiver should return after each transmitted frame. Each time the MAC's transmit enable goes low, the block opens a listening window of 96 bit times, which is one inter-frame gap. If the collision line pulses anywhere inside that window, the frame is considered healthy. If the window runs out and no pulse has arrived, the frame is a heartbeat failure, and an 8-bit statistics count goes up by one.

The window is timed by a one-cycle bit-time enable pulse that the MAC derives from its own clock. The block ignores every frame while the link runs in full duplex. If a new transmission starts before the window expires, the pending window is dropped without counting.

The count saturates at its maximum value. Software reads it as a 32-bit value whose upper bits are zero, and it may overwrite the 8 count bits at any time. A write has priority over an increment that falls in the same cycle.

Top module: `sqe_hb_monitor`

## Requirements
- R1: After reset the count is 0, and bits 31:8 of `stat_rd` read as 0 at all times.
- R2: In half duplex, when `tx_en` has fallen and 96 `bit_tick` pulses pass with `col` low and `tx_en` low, the count rises by exactly one. It shows on `stat_rd` in the cycle after the cycle of the 96th pulse.
- R3: A `col` high in any cycle of an open window closes that window with no error. This includes the cycle of the 96th pulse.
- R4: In full duplex (`half_duplex` = 0) no frame is counted. If `half_duplex` drops while a window is open, that window is abandoned.
- R5: Only cycles with `bit_tick` = 1 advance the window. After 95 pulses nothing has been counted yet, however many cycles have passed.
- R6: If `tx_en` rises again before the 96th pulse, the pending window is dropped uncounted. A new window opens at the next fall of `tx_en`.
- R7: At a count of 255, a further failure leaves the count at 255.
- R8: With `wr_en` = 1, the count takes `wr_data[7:0]` on the next cycle. This holds even when a failure is detected in that same cycle. Bits 31:8 of `wr_data` have no effect.
- R9: A `col` pulse while `tx_en` is high, or in the first cycle in which `tx_en` is seen low, is not taken as a heartbeat. The window starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable from the MAC |
| col | input | 1 | Collision / heartbeat line from the transceiver |
| half_duplex | input | 1 | 1 = half duplex, 0 = full duplex |
| wr_en | input | 1 | Software write strobe for the count |
| wr_data | input | 32 | Write data; only bits 7:0 are used |
| stat_rd | output | 32 | Count value, zero-extended |

## Verification
The count is the only visible state, so a fault in the window tracker shows up only as a count that moves at the wrong time. A window that is wrongly kept open, a timer that is off by one, or a heartbeat that is missed all change `stat_rd` one cycle after the decisive tick, or fail to change it there. Checking the count on every cycle against a model therefore pins the error to the exact tick. A faulty saturation or write-priority path is visible on the very next cycle.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;
  // Tracker phases: idle, frame on the wire, listening window
  typedef enum logic [1:0] {
    HB_IDLE = 2'd0,
    HB_TX   = 2'd1,
    HB_WAIT = 2'd2
  } hb_state_e;
endpackage

// File: rtl/sqe_hb_window.sv
module sqe_hb_window
  import sqe_hb_pkg::*;
#(
  parameter int WINDOW_TICKS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic col,
  input  logic half_duplex,
  output logic win_open,
  output logic hb_seen,
  output logic hb_abandon,
  output logic hb_miss
);
  localparam int TMR_W = $clog2(WINDOW_TICKS);

  hb_state_e        state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  function automatic logic on_last_tick(input logic [TMR_W-1:0] t);
    return t == TMR_W'(WINDOW_TICKS - 1);
  endfunction

  assign win_open   = (state_q == HB_WAIT);
  assign hb_abandon = win_open && (tx_en || !half_duplex);
  assign hb_seen    = win_open && !hb_abandon && col;
  assign hb_miss    = win_open && !hb_abandon && !col && bit_tick && on_last_tick(tmr_q);

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      HB_IDLE: if (tx_en) state_d = HB_TX;
      HB_TX: begin
        if (!tx_en) begin
          state_d = half_duplex ? HB_WAIT : HB_IDLE;
          tmr_d   = '0;
        end
      end
      HB_WAIT: begin
        if (tx_en)                     state_d = HB_TX;
        else if (hb_abandon || hb_seen) state_d = HB_IDLE;
        else if (hb_miss)              state_d = HB_IDLE;
        else if (bit_tick)             tmr_d   = tmr_q + 1'b1;
      end
      default: state_d = HB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HB_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end
endmodule

// File: rtl/sqe_hb_count.sv
module sqe_hb_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_val;
    else if (bump)  count <= sat_inc(count);
  end
endmodule

// File: rtl/sqe_hb_monitor.sv
module sqe_hb_monitor #(
  parameter int WINDOW_TICKS = 96,
  parameter int CNT_W        = 8,
  parameter int REG_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_en,
  input  logic             col,
  input  logic             half_duplex,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] stat_rd
);
  localparam int PAD_W = REG_W - CNT_W;

  logic             win_open, hb_seen, hb_abandon, hb_miss;
  logic [CNT_W-1:0] count;

  sqe_hb_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .col(col), .half_duplex(half_duplex), .win_open(win_open),
    .hb_seen(hb_seen), .hb_abandon(hb_abandon), .hb_miss(hb_miss)
  );

  sqe_hb_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_data[CNT_W-1:0]),
    .bump(hb_miss), .count(count)
  );

  assign stat_rd = {{PAD_W{1'b0}}, count};
endmodule

// File: rtl/sqe_hb_monitor_chk.sv
module sqe_hb_monitor_chk #(
  parameter int CNT_W = 8,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             col,
  input logic             half_duplex,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] stat_rd,
  input logic             win_open,
  input logic             hb_miss
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [CNT_W-1:0] cnt;
  assign cnt = stat_rd[CNT_W-1:0];

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[REG_W-1:CNT_W] == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && hb_miss && cnt != CMAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  a_r3_col_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> !hb_miss);
  a_r4_fd_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex |-> !hb_miss);
  a_r6_tx_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !hb_miss);
  a_r9_miss_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    hb_miss |-> win_open);
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt == CMAX) |=> cnt == CMAX);
  a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data[CNT_W-1:0]));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !hb_miss) |=> $stable(cnt));
endmodule

bind sqe_hb_monitor sqe_hb_monitor_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .col(col),
  .half_duplex(half_duplex), .wr_en(wr_en), .wr_data(wr_data),
  .stat_rd(stat_rd), .win_open(win_open), .hb_miss(hb_miss)
);

// File: tb/sqe_hb_monitor_test.sv
module sqe_hb_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, tx_en = 1'b0, col = 1'b0, half_duplex = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] stat_rd;

  int n_chk = 0, n_bad = 0;

  // reference model state
  int m_cnt = 0;
  bit m_prev_tx = 0, m_pend = 0;
  int m_ticks = 0;

  always #4 clk = ~clk;

  sqe_hb_monitor uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .col(col),
    .half_duplex(half_duplex), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd)
  );

  // Reference: window counted in bit ticks after the first idle cycle.
  function automatic int next_count(int c, bit w, int wv, bit fail);
    if (w) return wv & 255;
    if (fail) return (c >= 255) ? 255 : c + 1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit fail;
    if (!rst_n) begin
      m_cnt = 0; m_prev_tx = 0; m_pend = 0; m_ticks = 0;
    end else begin
      fail = 0;
      if (tx_en) begin
        m_prev_tx = 1; m_pend = 0;
      end else if (m_prev_tx) begin
        m_prev_tx = 0; m_pend = half_duplex; m_ticks = 0;
      end else if (m_pend) begin
        if (!half_duplex || col) m_pend = 0;
        else if (bit_tick) begin
          m_ticks++;
          if (m_ticks == 96) begin fail = 1; m_pend = 0; end
        end
      end
      m_cnt = next_count(m_cnt, wr_en, int'(wr_data), fail);
    end
  end

  task automatic check(string tag, int exp);
    n_chk++;
    if (stat_rd !== 32'(exp)) begin
      n_bad++;
      $display("FAIL %s: stat_rd=%0d expected %0d", tag, stat_rd, exp);
    end
  endtask

  task automatic cyc(bit t, bit k, bit c, bit h, bit w, logic [31:0] d);
    tx_en = t; bit_tick = k; col = c; half_duplex = h; wr_en = w; wr_data = d;
    @(negedge clk);
  endtask

  // frame, then n_ticks ticks spaced by gap idle cycles; col on tick index col_at
  task automatic frame(int n_ticks, int col_at, bit h, int gap);
    for (int i = 0; i < 4; i++) cyc(1, 1, (i == 2), h, 0, 0);
    cyc(0, 1, 0, h, 0, 0);
    for (int i = 1; i <= n_ticks; i++) begin
      for (int g = 0; g < gap; g++) cyc(0, 0, 0, h, 0, 0);
      cyc(0, 1, (i == col_at), h, 0, 0);
    end
  endtask

  initial begin
    int base, seed, burst;
    bit t, hd;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 0);

    frame(95, 0, 1, 0);
    check("R5 after 95 ticks", 0);
    cyc(0, 1, 0, 1, 0, 0);
    check("R2 96th tick counts", 1);
    check("R2 model", m_cnt);

    frame(96, 96, 1, 0); cyc(0, 0, 0, 1, 0, 0);
    check("R3 col on last tick", 1);
    frame(96, 40, 1, 0); cyc(0, 0, 0, 1, 0, 0);
    check("R3 col mid window", 1);

    frame(96, 0, 1, 2); cyc(0, 0, 0, 1, 0, 0);
    check("R5 spaced ticks", 2);

    frame(96, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    check("R4 full duplex", 2);
    frame(50, 0, 1, 0);
    for (int i = 0; i < 60; i++) cyc(0, 1, 0, (i == 0) ? 1'b0 : 1'b1, 0, 0);
    check("R4 duplex drop abandons", 2);

    frame(90, 0, 1, 0);
    frame(10, 0, 1, 0);
    check("R6 restart abandons", 2);
    for (int i = 0; i < 86; i++) cyc(0, 1, 0, 1, 0, 0);
    check("R6 new window counts", 3);

    // R9: col in first idle cycle is ignored
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 0);
    cyc(0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 96; i++) cyc(0, 1, 0, 1, 0, 0);
    check("R9 early col ignored", 4);

    cyc(0, 0, 0, 1, 1, 32'hABCD_12FE);
    check("R8 write low byte only", 8'hFE);
    frame(96, 0, 1, 0); check("R7 to 255", 255);
    frame(96, 0, 1, 0); check("R7 saturates", 255);

    frame(95, 0, 1, 0);
    cyc(0, 1, 0, 1, 1, 32'd7);
    check("R8 write beats increment", 7);

    // constrained random phase
    burst = 0; t = 0; hd = 1;
    for (int i = 0; i < 6000; i++) begin
      if (burst == 0) begin
        t = ~t;
        burst = t ? 2 + int'($urandom_range(20)) : 20 + int'($urandom_range(250));
        if ($urandom_range(15) == 0) hd = ~hd;
      end
      burst--;
      cyc(t, $urandom_range(1) == 1, $urandom_range(150) == 0, hd,
          $urandom_range(700) == 0, $urandom);
      check("R2 random vs model", m_cnt);
    end

    base = m_cnt;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: stat_rd=%0d expected finish", stat_rd);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule